// File: doc/BRIEF.md
# Soft-Ramping Linear Volume Control

This block is a bank of digital attenuators placed just ahead of a DAC, one per audio channel. Each channel holds an applied gain level, an 8-bit linear code. It scales every incoming signed sample by level/255, rounded to the nearest integer, so code 255 is unity gain and code 0 is silence.

When software writes a new target code, the applied level does not jump to it. It moves one code at a time toward the target, waiting a fixed number of sample frames between steps. The wait depends on the sample-rate mode and doubles with each faster mode. The frame wait therefore stays the same length in absolute time, and the gain change makes no audible click. A per-channel busy flag stays high for as long as the applied level has not reached the target.

Samples and steps both advance on `frame_stb`, which pulses for one clock per sample frame. Each channel's target and sample arrive on flattened buses.

Top module: `vol_ctrl`

## Requirements
- R1: After reset every channel's applied level is 255 and every scaled output is 0. With a target of 255, busy is low.
- R2: On a clock edge where `frame_stb` is high, the channel output register loads round(sample × level / 255), computed with the level in force before that edge. Rounding takes the magnitude as floor((|sample|×level + 127)/255) and then restores the sign. The output holds between strobes.
- R3: Level 255 passes each sample through exactly, including full-scale positive and negative values. Level 0 gives an output of 0.
- R4: The applied level changes only on strobe edges, never by more than one code per edge, and always in the direction of the target.
- R5: The step interval is 4 strobes when `speed`=0 (normal), 8 when `speed`=1 (double) and 16 when `speed` is 2 or 3 (quad). A full 255→0 ramp therefore takes 1020, 2040 or 4080 strobes.
- R6: A new target written during a ramp redirects the ramp from the current level. The frame counter is not restarted.
- R7: `busy[k]` is high exactly while channel k's applied level differs from its target.
- R8: Channels are independent. Channel k uses `sample_in[k*24 +: 24]`, `target_code[k*8 +: 8]`, `sample_out[k*24 +: 24]` and `busy[k]`.
- R9: The frame counter is cleared whenever the level equals the target. The first step of a new ramp therefore comes a full interval after it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-clock pulse per sample frame |
| speed | input | 2 | Rate mode: 0 normal, 1 double, 2/3 quad |
| target_code | input | NUM_CH*8 | Per-channel target gain codes |
| sample_in | input | NUM_CH*24 | Per-channel signed input samples |
| sample_out | output | NUM_CH*24 | Per-channel scaled samples |
| busy | output | NUM_CH | Per-channel ramp-in-progress flags |

## Verification
The bench builds the block with its default values: two channels, 24-bit samples and a base interval of four frames. With these values the interval is 4, 8 or 16 strobes, so full 255→0 and 0→255 ramps fit in a few thousand strobes, and every mode, including the alternate quad encoding, can be timed strobe by strobe. Keeping channel 1 at unity while channel 0 ramps exposes any cross-channel coupling. Samples around the ±0.5 rounding points and at full scale check the divide-by-255 rounding.

// File: rtl/vol_pkg.sv
package vol_pkg;
    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'd0,
        SPD_DOUBLE   = 2'd1,
        SPD_QUAD     = 2'd2,
        SPD_QUAD_ALT = 2'd3
    } speed_e;

    // log2 of the interval multiplier for each rate mode
    function automatic int unsigned speed_shift(input speed_e s);
        case (s)
            SPD_NORMAL: speed_shift = 0;
            SPD_DOUBLE: speed_shift = 1;
            default:    speed_shift = 2;
        endcase
    endfunction
endpackage

// File: rtl/vol_ramp.sv
module vol_ramp
    import vol_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int BASE_FRAMES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [1:0]       speed,
    input  logic [LVL_W-1:0] target,
    output logic [LVL_W-1:0] level,
    output logic             busy
);
    localparam int MAX_INTERVAL = BASE_FRAMES * 4;
    localparam int CNT_W        = $clog2(MAX_INTERVAL);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [CNT_W-1:0] cnt;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = CNT_W'((BASE_FRAMES << speed_shift(speed_e'(speed))) - 1);
        st_d = st_q;
        if (st_q.level == target) begin
            st_d.cnt = '0;
        end else if (frame_stb) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt = '0;
                if (target > st_q.level) st_d.level = st_q.level + 1'b1;
                else                     st_d.level = st_q.level - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= LVL_MAX;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign busy  = (st_q.level != target);

    // R4: level moves only on strobe edges
    a_r4_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(st_q.level));
    // R4: at most one code per edge
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.level == $past(st_q.level)) ||
                 (st_q.level == $past(st_q.level) + 1'b1) ||
                 (st_q.level == $past(st_q.level) - 1'b1));
    // R4: an upward step only happens toward a higher target
    a_r4_up_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level > $past(st_q.level)) |-> ($past(target) > $past(st_q.level)));
    // R4: a downward step only happens toward a lower target
    a_r4_down_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level < $past(st_q.level)) |-> ($past(target) < $past(st_q.level)));
    // R9: counter is cleared once the level reaches the target
    a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level == target) |=> (st_q.cnt == '0));
endmodule

// File: rtl/vol_scale.sv
module vol_scale #(
    parameter int DW    = 24,
    parameter int LVL_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic [LVL_W-1:0]        level,
    input  logic signed [DW-1:0]    sample_in,
    output logic signed [DW-1:0]    sample_out
);
    localparam int PW = DW + 1 + LVL_W;
    localparam logic [PW-1:0] DIVISOR = PW'((1 << LVL_W) - 1);
    localparam logic [PW-1:0] HALF    = PW'(((1 << LVL_W) - 1) / 2);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    typedef struct packed {
        logic signed [DW-1:0] out;
    } scale_st_t;

    scale_st_t st_d, st_q;
    logic          neg;
    logic [DW:0]   mag;
    logic [PW-1:0] prod;
    logic [PW-1:0] quot;
    logic [DW:0]   res;

    always_comb begin
        neg  = sample_in[DW-1];
        mag  = neg ? (DW+1)'(-$signed({sample_in[DW-1], sample_in}))
                   : {1'b0, sample_in};
        prod = PW'(mag) * PW'(level);
        quot = (prod + HALF) / DIVISOR;
        res  = neg ? (DW+1)'(-quot) : quot[DW:0];
        st_d = st_q;
        if (frame_stb) st_d.out = res[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.out <= '0;
        else        st_q <= st_d;
    end

    assign sample_out = st_q.out;

    // R3: unity code passes the sample through exactly
    a_r3_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && level == LVL_MAX) |=> (sample_out == $past(sample_in)));
    // R3: code zero silences the output
    a_r3_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && level == '0) |=> (sample_out == '0));
    // R2: output holds between strobes
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(sample_out));
endmodule

// File: rtl/vol_ctrl.sv
module vol_ctrl #(
    parameter int NUM_CH      = 2,
    parameter int DW          = 24,
    parameter int LVL_W       = 8,
    parameter int BASE_FRAMES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic [1:0]              speed,
    input  logic [NUM_CH*LVL_W-1:0] target_code,
    input  logic [NUM_CH*DW-1:0]    sample_in,
    output logic [NUM_CH*DW-1:0]    sample_out,
    output logic [NUM_CH-1:0]       busy
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [LVL_W-1:0] lvl;

        vol_ramp #(.LVL_W(LVL_W), .BASE_FRAMES(BASE_FRAMES)) u_ramp (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_stb (frame_stb),
            .speed     (speed),
            .target    (target_code[k*LVL_W +: LVL_W]),
            .level     (lvl),
            .busy      (busy[k])
        );

        vol_scale #(.DW(DW), .LVL_W(LVL_W)) u_scale (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_stb  (frame_stb),
            .level      (lvl),
            .sample_in  (sample_in[k*DW +: DW]),
            .sample_out (sample_out[k*DW +: DW])
        );

        // R7: busy goes low only once the level has landed on the target
        a_r7_busy_settle: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(busy[k]) && $stable(target_code[k*LVL_W +: LVL_W]))
                |-> (lvl == target_code[k*LVL_W +: LVL_W]));
    end
endmodule

// File: tb/tb_vol_ctrl.sv
module tb_vol_ctrl;
    localparam int NUM_CH = 2;
    localparam int DW     = 24;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  frame_stb = 1'b0;
    logic [1:0]            speed = 2'd0;
    logic [NUM_CH*8-1:0]   target_code = {NUM_CH{8'hFF}};
    logic [NUM_CH*DW-1:0]  sample_in = '0;
    logic [NUM_CH*DW-1:0]  sample_out;
    logic [NUM_CH-1:0]     busy;

    int n_chk = 0;
    int n_bad = 0;
    int cur_lvl = 255;

    always #2.5 clk = ~clk;

    vol_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .speed(speed),
        .target_code(target_code), .sample_in(sample_in),
        .sample_out(sample_out), .busy(busy)
    );

    function automatic int expect_scale(input int s, input int c);
        longint m, q;
        m = (s < 0) ? -longint'(s) : longint'(s);
        q = (m * c + 127) / 255;
        return (s < 0) ? int'(-q) : int'(q);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int s0, input int s1);
        @(negedge clk);
        sample_in = {DW'(s1), DW'(s0)};
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    function automatic int out_ch(input int k);
        return int'($signed(sample_out[k*DW +: DW]));
    endfunction

    // Ramp channel 0 to code, count strobes until busy drops
    task automatic ramp_to(input int code, input int interval, input string tag);
        int n;
        int diff;
        @(negedge clk);
        target_code[7:0] = 8'(code);
        #1;
        check({tag, " R7 busy on write"}, busy[0], (code != cur_lvl) ? 1 : 0);
        n = 0;
        while (busy[0] && n < 20000) begin
            pulse(0, 1000);
            n++;
        end
        diff = (code > cur_lvl) ? code - cur_lvl : cur_lvl - code;
        check({tag, " R5/R9 strobe count"}, n, diff * interval);
        cur_lvl = code;
    endtask

    localparam int NV = 9;
    localparam int V_CODE [NV] = '{255, 255, 250, 128, 128, 1, 1, 1, 0};
    localparam int V_SAMP [NV] = '{8388607, -8388608, 1000, 12345, -12345,
                                   127, 128, -128, 8388607};

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out ch0", out_ch(0), 0);
        check("R1 reset out ch1", out_ch(1), 0);
        check("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        pulse(8388607, 8388607);
        check("R1 level 255 after reset", out_ch(0), 8388607);

        // table walk at normal speed: ramp, then scale (R2, R3, R8)
        for (int i = 0; i < NV; i++) begin
            ramp_to(V_CODE[i], 4, "vec");
            pulse(V_SAMP[i], -77);
            check("R2/R3 scaled output", out_ch(0), expect_scale(V_SAMP[i], V_CODE[i]));
            check("R8 ch1 untouched", out_ch(1), -77);
            check("R8 ch1 busy low", busy[1], 0);
        end

        // R5: mode timing, including the alternate quad encoding
        speed = 2'd1; ramp_to(10, 8, "R5 double");
        speed = 2'd2; ramp_to(0, 16, "R5 quad");
        speed = 2'd3; ramp_to(5, 16, "R5 quad alt");
        speed = 2'd0; ramp_to(255, 4, "R5 normal up");
        ramp_to(0, 4, "R5 full 255->0 normal");
        speed = 2'd2; ramp_to(255, 16, "R5 full 0->255 quad");

        // R6: reverse mid-ramp; 10 strobes of 255->200 leave 253, count 2
        speed = 2'd0;
        @(negedge clk); target_code[7:0] = 8'd200;
        for (int i = 0; i < 10; i++) pulse(0, 0);
        pulse(255, 0);
        check("R6 level mid ramp", out_ch(0), 253);
        // now 11 strobes in: counter at 3, next strobe steps
        @(negedge clk); target_code[7:0] = 8'd254;
        pulse(255, 0);
        check("R6 no restart, level still 253 at step", out_ch(0), 253);
        pulse(255, 0);
        check("R6 first step after retarget", out_ch(0), 254);
        check("R7 busy clear at new target", busy[0], 0);

        // R6: same-direction retarget; 254 -> 240, 6 strobes leave 253 count 2
        @(negedge clk); target_code[7:0] = 8'd240;
        for (int i = 0; i < 6; i++) pulse(0, 0);
        @(negedge clk); target_code[7:0] = 8'd250;
        begin
            int n = 0;
            while (busy[0] && n < 200) begin pulse(0, 0); n++; end
            check("R6 strobes to 250 after retarget", n, 10);
        end
        pulse(255, 0);
        check("R6 level reached 250", out_ch(0), 250);

        // R8: channel 1 ramps alone while channel 0 stays put
        @(negedge clk); target_code[15:8] = 8'd253;
        #1;
        check("R8 ch1 busy", busy[1], 1);
        check("R8 ch0 idle", busy[0], 0);
        for (int i = 0; i < 8; i++) pulse(0, 0);
        pulse(255, 255);
        check("R8 ch1 level", out_ch(1), 253);
        check("R8 ch0 level", out_ch(0), 250);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule